// File: doc/BRIEF.md
# Pulse Width and Period Meter

This block times a digital input signal and reports how long it stays high, how long it stays low, or how long one full cycle lasts, in counts of a divided base clock. One of three trigger inputs is selected: two pin inputs or a comparator output. The selected signal is synchronised, then passed through a glitch filter, and only then used for edge detection. A fourth mode records the low width and the period of the same cycle together and publishes both with a single completion flag.

Software sets the mode, the source and the divider, then raises `enable`. The block arms on the first qualifying edge, so a pulse already in progress when `enable` rises is not measured. Each completed measurement is latched into the result outputs and raises `done`. A one-cycle pulse on `clr_done` clears `done`. If the running count would pass full scale, the count saturates and `ovf` is set. A parameter selects the filter length and the divider step: 3 ticks with ratios 1 to 8 (default), or 6 ticks with ratios 2 to 16.

Top module: `pulse_meter`

## Requirements
- R1: After reset, `done` and `ovf` are 0 and both `width_res` and `period_res` are 0.
- R2: `src_sel` picks the trigger input. 0 selects `pin_a`, 1 selects `pin_b`, 2 selects `cmp_in`, and 3 selects `pin_a`. Activity on inputs that are not selected produces no completion.
- R3: One base tick occurs every (div_sel+1)*DIV_STEP clock cycles. DIV_STEP is 1 by default. Every result is a count of base ticks.
- R4: The filtered level changes only after the synchronised input has differed from it on FILT_LEN consecutive ticks (3 by default). At a ratio of 1, a pulse of 2 clocks is rejected, a pulse of 3 clocks is accepted, and a 2-clock dip inside a longer pulse leaves that pulse whole.
- R5: With `mode`=0, the high time from a rising edge to the next falling edge is written to `width_res`.
- R6: With `mode`=1, the low time from a falling edge to the next rising edge is written to `width_res`.
- R7: With `mode`=2, the time between two successive falling edges is written to `period_res`. Each falling edge that ends a period also starts the next one, so periods are reported back to back.
- R8: With `mode`=3, one `done` delivers both the low time (on `width_res`) and the fall-to-fall period (on `period_res`) of the same cycle.
- R9: Measurement starts on the first start edge after `enable` rises, so a level already in progress is ignored. While `enable` is 0, no measurement completes.
- R10: `done` rises on each completion and holds until a `clr_done` pulse clears it. If a completion and a clear arrive in the same cycle, the completion wins.
- R11: A count that passes 2^CNT_W-1 saturates there, and the reported result is 2^CNT_W-1. `ovf` is then set and stays set until `clr_done`.
- R12: `width_res` and `period_res` change only on a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run control; low returns the meter to idle |
| mode | input | 2 | 0 high width, 1 low width, 2 period, 3 low width plus period |
| src_sel | input | 2 | Trigger source select |
| div_sel | input | 3 | Base-clock ratio select |
| clr_done | input | 1 | Clear pulse for `done` and `ovf` |
| pin_a | input | 1 | Trigger input, source 0 and 3 |
| pin_b | input | 1 | Trigger input, source 1 |
| cmp_in | input | 1 | Comparator output, source 2 |
| width_res | output | CNT_W | Latched high or low width |
| period_res | output | CNT_W | Latched period |
| done | output | 1 | Measurement complete flag |
| ovf | output | 1 | Saturation flag |

## Verification
Most faults inside the meter show up at the ports as a wrong count in the next result.

- **Filter counter:** a fault here moves an accepted edge by a whole tick. The first width after the fault is then off by one.
- **Arming state:** a fault here raises `done` for a pulse that began before `enable`. A monitor that expects no item at that point catches it within a few ticks of that edge.
- **Dual-mode hold register:** a fault here gives a low width that does not belong to the period reported beside it.
- **Saturation path:** a fault here leaves `ovf` low, or lets the result wrap to a small value, on the single long pulse that crosses full scale.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        MODE_HIGH   = 2'd0,
        MODE_LOW    = 2'd1,
        MODE_PERIOD = 2'd2,
        MODE_DUAL   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } meas_st_e;

endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
    parameter int DIV_STEP = 1,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int MAX_RATIO = (1 << SEL_W) * DIV_STEP;
    localparam int RAT_W     = $clog2(MAX_RATIO + 1);

    typedef struct packed {
        logic [RAT_W-1:0] cnt;
    } tick_s;

    tick_s            t_d, t_q;
    logic [RAT_W-1:0] ratio;
    int               ratio_i;

    always_comb begin
        ratio_i = (int'(div_sel) + 1) * DIV_STEP;
        ratio   = RAT_W'(ratio_i);
        tick    = (t_q.cnt >= ratio - 1'b1);
        t_d     = t_q;
        if (tick) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/pm_edge_filter.sv
module pm_edge_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       pin_a,
    input  logic       pin_b,
    input  logic       cmp_in,
    input  logic       tick,
    output logic       rise,
    output logic       fall
);
    localparam int STAB_W = $clog2(FILT_LEN + 1);
    localparam logic [STAB_W-1:0] STAB_LAST = STAB_W'(FILT_LEN - 1);

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              lvl;
        logic [STAB_W-1:0] stab;
    } filt_s;

    filt_s f_d, f_q;
    logic  sel_in;
    logic  accept;

    always_comb begin
        case (src_sel)
            2'd1:    sel_in = pin_b;
            2'd2:    sel_in = cmp_in;
            default: sel_in = pin_a;
        endcase

        f_d    = f_q;
        f_d.s1 = sel_in;
        f_d.s2 = f_q.s1;
        accept = 1'b0;

        if (tick) begin
            if (f_q.s2 == f_q.lvl) begin
                f_d.stab = '0;
            end else if (f_q.stab == STAB_LAST) begin
                f_d.lvl  = f_q.s2;
                f_d.stab = '0;
                accept   = 1'b1;
            end else begin
                f_d.stab = f_q.stab + 1'b1;
            end
        end

        rise = accept && f_q.s2;
        fall = accept && !f_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end
endmodule

// File: rtl/pm_measure.sv
module pm_measure
    import pm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  mode_e            mode,
    input  logic             tick,
    input  logic             rise,
    input  logic             fall,
    input  logic             clr_done,
    output logic [CNT_W-1:0] width_res,
    output logic [CNT_W-1:0] period_res,
    output logic             done,
    output logic             ovf,
    output logic             done_set
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        meas_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] low_hold;
        logic             mid;
        logic [CNT_W-1:0] width;
        logic [CNT_W-1:0] period;
        logic             done;
        logic             ovf;
    } meas_s;

    meas_s            m_d, m_q;
    logic             at_max;
    logic [CNT_W-1:0] bumped;
    logic             start_e;

    always_comb begin
        m_d      = m_q;
        done_set = 1'b0;
        at_max   = (m_q.cnt == CMAX);
        bumped   = at_max ? CMAX : m_q.cnt + 1'b1;
        start_e  = (mode == MODE_HIGH) ? rise : fall;

        if (clr_done) begin
            m_d.done = 1'b0;
            m_d.ovf  = 1'b0;
        end

        if (!enable) begin
            m_d.st  = ST_IDLE;
            m_d.cnt = '0;
            m_d.mid = 1'b0;
        end else begin
            case (m_q.st)
                ST_IDLE, ST_ARM: begin
                    if (start_e) begin
                        m_d.st  = ST_RUN;
                        m_d.cnt = '0;
                        m_d.mid = 1'b0;
                    end else begin
                        m_d.st = ST_ARM;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        m_d.cnt = bumped;
                        if (at_max) begin
                            m_d.ovf = 1'b1;
                        end
                    end
                    case (mode)
                        MODE_HIGH: begin
                            if (fall) begin
                                m_d.width = bumped;
                                m_d.done  = 1'b1;
                                done_set  = 1'b1;
                                m_d.st    = ST_ARM;
                            end
                        end
                        MODE_LOW: begin
                            if (rise) begin
                                m_d.width = bumped;
                                m_d.done  = 1'b1;
                                done_set  = 1'b1;
                                m_d.st    = ST_ARM;
                            end
                        end
                        MODE_PERIOD: begin
                            if (fall) begin
                                m_d.period = bumped;
                                m_d.done   = 1'b1;
                                done_set   = 1'b1;
                                m_d.cnt    = '0;
                            end
                        end
                        default: begin
                            if (rise && !m_q.mid) begin
                                m_d.low_hold = bumped;
                                m_d.mid      = 1'b1;
                            end else if (fall && m_q.mid) begin
                                m_d.width  = m_q.low_hold;
                                m_d.period = bumped;
                                m_d.done   = 1'b1;
                                done_set   = 1'b1;
                                m_d.cnt    = '0;
                                m_d.mid    = 1'b0;
                            end
                        end
                    endcase
                end
                default: m_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign width_res  = m_q.width;
    assign period_res = m_q.period;
    assign done       = m_q.done;
    assign ovf        = m_q.ovf;
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
    import pm_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter bit WIDE_FILTER = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic [1:0]       src_sel,
    input  logic [2:0]       div_sel,
    input  logic             clr_done,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             cmp_in,
    output logic [CNT_W-1:0] width_res,
    output logic [CNT_W-1:0] period_res,
    output logic             done,
    output logic             ovf
);
    localparam int FILT_LEN = WIDE_FILTER ? 6 : 3;
    localparam int DIV_STEP = WIDE_FILTER ? 2 : 1;

    logic tick_w;
    logic rise_w;
    logic fall_w;
    logic done_set_w;

    pm_tick_gen #(
        .DIV_STEP (DIV_STEP),
        .SEL_W    (3)
    ) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick    (tick_w)
    );

    pm_edge_filter #(
        .FILT_LEN (FILT_LEN)
    ) i_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .pin_a   (pin_a),
        .pin_b   (pin_b),
        .cmp_in  (cmp_in),
        .tick    (tick_w),
        .rise    (rise_w),
        .fall    (fall_w)
    );

    pm_measure #(
        .CNT_W (CNT_W)
    ) i_meas (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .mode       (mode_e'(mode)),
        .tick       (tick_w),
        .rise       (rise_w),
        .fall       (fall_w),
        .clr_done   (clr_done),
        .width_res  (width_res),
        .period_res (period_res),
        .done       (done),
        .ovf        (ovf),
        .done_set   (done_set_w)
    );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             clr_done,
    input logic             done,
    input logic             ovf,
    input logic [CNT_W-1:0] width_res,
    input logic [CNT_W-1:0] period_res,
    input logic             tick,
    input logic             rise,
    input logic             fall,
    input logic             done_set
);
    // R9: a disabled meter never completes
    a_r9_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !$rose(done));

    // R10: a clear with no completion drops done
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !done_set) |=> !done);

    // R10: done holds until cleared
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_done) |=> done);

    // R11: the saturation flag holds until cleared
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_done) |=> ovf);

    // R12: results move only on a completion
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_set |=> ($stable(width_res) && $stable(period_res)));

    // R4: filtered edges appear only on base ticks
    a_r4_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |-> tick);
endmodule

bind pulse_meter pm_checker #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .clr_done   (clr_done),
    .done       (done),
    .ovf        (ovf),
    .width_res  (width_res),
    .period_res (period_res),
    .tick       (tick_w),
    .rise       (rise_w),
    .fall       (fall_w),
    .done_set   (done_set_w)
);

// File: tb/test_pulse_meter.sv
module test_pulse_meter;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic [1:0]       src_sel = 2'd0;
    logic [2:0]       div_sel = 3'd0;
    logic             clr_done = 1'b0;
    logic             pin_a = 1'b0;
    logic             pin_b = 1'b0;
    logic             cmp_in = 1'b0;
    logic [CNT_W-1:0] width_res;
    logic [CNT_W-1:0] period_res;
    logic             done;
    logic             ovf;

    typedef struct {
        bit chk_w;
        bit chk_p;
        int w;
        int p;
        bit ov;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   drv_src = 0;
    bit   clr_pend = 1'b0;

    always #10 clk = ~clk;

    pulse_meter #(.CNT_W(CNT_W)) i_pulse_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .mode       (mode),
        .src_sel    (src_sel),
        .div_sel    (div_sel),
        .clr_done   (clr_done),
        .pin_a      (pin_a),
        .pin_b      (pin_b),
        .cmp_in     (cmp_in),
        .width_res  (width_res),
        .period_res (period_res),
        .done       (done),
        .ovf        (ovf)
    );

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic hold(bit v, int n);
        case (drv_src)
            1:       pin_b = v;
            2:       cmp_in = v;
            default: pin_a = v;
        endcase
        repeat (n) @(negedge clk);
    endtask

    task automatic push(bit cw, bit cp, int w, int p, bit ov, string req);
        exp_t e;
        e.chk_w = cw; e.chk_p = cp; e.w = w; e.p = p; e.ov = ov; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic restart(int m);
        enable = 1'b0;
        @(negedge clk);
        mode = 2'(m);
        @(negedge clk);
        enable = 1'b1;
    endtask

    // monitor: pops expected items as the meter completes
    initial begin
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (clr_pend) begin
                chk(done == 1'b0, "R10", "done after clear", int'(done), 0);
                clr_done = 1'b0;
                clr_pend = 1'b0;
            end else if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected completion", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    if (e.chk_w) chk(int'(width_res) == e.w, e.req, "width", int'(width_res), e.w);
                    if (e.chk_p) chk(int'(period_res) == e.p, e.req, "period", int'(period_res), e.p);
                    chk(ovf == e.ov, "R11", "ovf flag", int'(ovf), int'(e.ov));
                end
                clr_done = 1'b1;
                clr_pend = 1'b1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1", "done", int'(done), 0);
        chk(ovf == 1'b0, "R1", "ovf", int'(ovf), 0);
        chk(width_res == '0, "R1", "width", int'(width_res), 0);
        chk(period_res == '0, "R1", "period", int'(period_res), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5/R4: high width, glitch rejection
        enable = 1'b1;
        hold(0, 10);
        hold(1, 7);  push(1, 0, 7, 0, 0, "R5");
        hold(0, 10);
        hold(1, 2);                              // R4: too short
        hold(0, 10);
        hold(1, 3);  push(1, 0, 3, 0, 0, "R4");  // R4: just long enough
        hold(0, 10);
        hold(1, 12); push(1, 0, 12, 0, 0, "R5");
        hold(0, 10);
        settle();
        chk(int'(width_res) == 12, "R12", "width held", int'(width_res), 12);

        // R4: short dip inside a pulse is filtered out
        hold(1, 5);
        hold(0, 2);
        hold(1, 5);  push(1, 0, 12, 0, 0, "R4");
        hold(0, 10);
        settle();

        // R6/R9: low width, enable while low ignores partial pulse
        restart(1);
        hold(0, 6);
        hold(1, 8);
        hold(0, 9);  push(1, 0, 9, 0, 0, "R6");
        hold(1, 5);
        settle();

        // R7: back-to-back periods
        restart(2);
        hold(0, 4);
        hold(1, 6);  push(0, 1, 0, 10, 0, "R7");
        hold(0, 3);
        hold(1, 5);  push(0, 1, 0, 8, 0, "R7");
        hold(0, 5);
        hold(1, 10);
        settle();

        // R8: low width and period together
        restart(3);
        hold(0, 4);
        hold(1, 6);  push(1, 1, 4, 10, 0, "R8");
        hold(0, 3);
        hold(1, 5);  push(1, 1, 3, 8, 0, "R8");
        hold(0, 5);
        hold(1, 10);
        settle();

        // R3: ratio 3, 12 clocks equal 4 ticks
        enable = 1'b0;
        hold(0, 20);
        mode = 2'd0;
        div_sel = 3'd2;
        @(negedge clk);
        enable = 1'b1;
        hold(0, 30);
        hold(1, 12); push(1, 0, 4, 0, 0, "R3");
        hold(0, 30);
        settle();
        div_sel = 3'd0;

        // R2: source select
        enable = 1'b0;
        src_sel = 2'd1;
        @(negedge clk);
        enable = 1'b1;
        pin_a = 1'b1;
        repeat (20) @(negedge clk);
        pin_a = 1'b0;
        repeat (20) @(negedge clk);
        chk(done == 1'b0, "R2", "unselected pin", int'(done), 0);
        drv_src = 1;
        hold(0, 10);
        hold(1, 6);  push(1, 0, 6, 0, 0, "R2");
        hold(0, 10);
        settle();
        enable = 1'b0;
        src_sel = 2'd2;
        @(negedge clk);
        enable = 1'b1;
        drv_src = 2;
        hold(0, 10);
        hold(1, 9);  push(1, 0, 9, 0, 0, "R2");
        hold(0, 10);
        settle();

        // R11: saturation
        enable = 1'b0;
        src_sel = 2'd0;
        drv_src = 0;
        @(negedge clk);
        enable = 1'b1;
        hold(0, 10);
        hold(1, 4100); push(1, 0, 4095, 0, 1, "R11");
        hold(0, 10);
        settle();

        // R9: disable mid-pulse, nothing completes; R12 result holds
        hold(1, 10);
        enable = 1'b0;
        hold(1, 5);
        hold(0, 20);
        chk(done == 1'b0, "R9", "done after disable", int'(done), 0);
        chk(int'(width_res) == 4095, "R12", "width held", int'(width_res), 4095);
        chk(ovf == 1'b0, "R11", "ovf cleared", int'(ovf), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule